// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address and cycle-control front end of a synchronous burst SRAM. On every rising clock edge it looks at two active-low address strobes (one for a processor, one for a memory controller), an active-high chip enable, an active-low advance input, a burst-order select pin and an active-low write control. When a strobe takes effect, it captures a new external address and records the cycle type. The cycle type is read, write or deselect.

After the capture, the block walks the two low address bits through a four-beat burst. Each cycle in which advance is low moves the burst one beat on. Each cycle in which advance is high is a wait cycle that holds the address. The order select chooses a linear sequence (add one modulo four) or an interleaved sequence (first address XOR a beat count). After the fourth beat the sequence wraps to the first address of the same burst. The upper address bits never change inside a burst. An output-enable input gates a data-valid flag for read cycles. The memory array and the output drivers sit outside this block.

Every state register changes on the clock edge at which its inputs are sampled. So the address, the cycle type and the data-valid flag show the effect of an edge right after that edge. The data-valid flag also follows the output-enable input without a clock.

Top module: `bsram_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block enters the deselect state. After that edge `cycle_o` is 2'b00, `addr_o` is zero and `data_valid_o` is 0.
- R2: When `proc_strobe_n` is low and `chip_en` is high at an edge, `addr_i` is captured. After that edge `addr_o` equals it and `cycle_o` is 2'b01 (read).
- R3: When `ctrl_strobe_n` is low and `chip_en` is high, and the processor strobe is not in effect, `addr_i` is captured. `cycle_o` becomes 2'b10 (write) when `wr_n` is low and 2'b01 (read) when `wr_n` is high.
- R4: When `ctrl_strobe_n` is low and `chip_en` is low, and the processor strobe is not in effect, `cycle_o` becomes 2'b00 (deselect) and `addr_o` keeps its value.
- R5: When both strobes are low with `chip_en` high, the processor strobe wins. The cycle becomes read (2'b01) whatever the value of `wr_n`.
- R6: With `order_sel` = 0 (linear), each advance adds one modulo four to the two low bits of `addr_o`. For example, 01 is followed by 10, 11 and then 00.
- R7: With `order_sel` = 1 (interleaved), the low bits are the first address XOR a beat count of 0, 1, 2 and 3. For example, 01 is followed by 00, 11 and then 10.
- R8: At an edge with both strobes high and `adv_n` high, `addr_o` is unchanged (wait cycle).
- R9: An advance after the fourth beat returns to the first address of the burst, and bits above the low two never change during a burst.
- R10: `data_valid_o` is 1 exactly when `cycle_o` is read and `oe_n` is low. `oe_n` has no effect on `addr_o`.
- R11: A low `proc_strobe_n` while `chip_en` is low captures nothing. With the controller strobe high and `adv_n` high, `addr_o` and `cycle_o` keep their values.
- R12: While the cycle is deselect, a low `adv_n` with both strobes high leaves `addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External address |
| proc_strobe_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| chip_en | input | 1 | Chip enable, active high |
| adv_n | input | 1 | Burst advance, active low; high means wait |
| wr_n | input | 1 | Write control for controller-strobed cycles, active low |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order |
| oe_n | input | 1 | Output enable, active low; gates data valid |
| addr_o | output | ADDR_W | Internal burst address |
| cycle_o | output | 2 | 00 deselect, 01 read, 10 write |
| data_valid_o | output | 1 | Read data valid |

## Verification
Two functions can fall in the same cycle: the processor strobe and the controller strobe can both be low at one edge. The controller strobe can also arrive with write requested while the processor strobe is also low. The bench provokes this by driving both strobes low with chip enable high and `wr_n` low, on a new address. The result is judged by whether the next cycle shows a read at the new address rather than a write. A second case has the processor strobe low while chip enable is low, next to a hold or advance; there the bench checks that nothing is captured.

// File: rtl/bseq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: cycle codes are visible at the top as 2-bit values.
package bseq_pkg;

    // Cycle type held for the current burst
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'b00,
        CYC_READ  = 2'b01,
        CYC_WRITE = 2'b10
    } cyc_e;

    // Action the state registers take at the next edge
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_LOAD  = 2'b01,
        ACT_STEP  = 2'b10,
        ACT_DESEL = 2'b11
    } act_e;

endpackage

// File: rtl/bseq_strobe_dec.sv
// Module: bseq_strobe_dec
// Decides, from the strobes, chip enable, advance and write control,
// what the burst state does at the next edge. The processor strobe
// counts only with chip enable high and beats the controller strobe.
// Assumes: all inputs are synchronous and sampled at the rising edge.
module bseq_strobe_dec
    import bseq_pkg::*;
(
    input  logic proc_strobe_n,
    input  logic ctrl_strobe_n,
    input  logic chip_en,
    input  logic adv_n,
    input  logic wr_n,
    input  cyc_e cur_cyc,
    output act_e act,
    output cyc_e new_cyc
);

    logic proc_hit;
    logic ctrl_hit;

    assign proc_hit = !proc_strobe_n && chip_en;
    assign ctrl_hit = !ctrl_strobe_n;

    // Priority decode of the next action and the cycle type to capture
    always_comb begin
        act     = ACT_HOLD;
        new_cyc = cur_cyc;
        if (proc_hit) begin
            act     = ACT_LOAD;
            new_cyc = CYC_READ;
        end else if (ctrl_hit) begin
            if (chip_en) begin
                act     = ACT_LOAD;
                new_cyc = wr_n ? CYC_READ : CYC_WRITE;
            end else begin
                act     = ACT_DESEL;
                new_cyc = CYC_IDLE;
            end
        end else if (!adv_n && (cur_cyc != CYC_IDLE)) begin
            act = ACT_STEP;
        end
    end

endmodule

// File: rtl/bseq_burst_state.sv
// Module: bseq_burst_state
// Holds the captured burst address, the beat counter and the cycle type.
// The beat counter wraps naturally at 2**BEAT_W.
// Assumes: ADDR_W > BEAT_W; reset is synchronous and active low.
module bseq_burst_state
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  cyc_e              new_cyc,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] beat_q,
    output cyc_e              cyc_q
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    // Update address, beat and cycle registers per the decoded action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            cyc_q  <= CYC_IDLE;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    base_q <= addr_i;
                    beat_q <= '0;
                    cyc_q  <= new_cyc;
                end
                ACT_STEP:  beat_q <= beat_q + BEAT_ONE;
                ACT_DESEL: cyc_q  <= CYC_IDLE;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/bseq_order_gen.sv
// Module: bseq_order_gen
// Forms the low address bits of the current beat from the first address
// and the beat count, in linear (add) or interleaved (XOR) order.
// Assumes: order_sel is static during a burst.
module bseq_order_gen #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] first_lo,
    input  logic [BEAT_W-1:0] beat,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] lo
);

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    assign lin_lo = first_lo + beat;

    // One XOR per low address bit for the interleaved order
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_lo[b] = first_lo[b] ^ beat[b];
    end

    // Select the order named by the pin
    always_comb begin
        lo = order_sel ? ilv_lo : lin_lo;
    end

endmodule

// File: rtl/bsram_addr_seq.sv
// Module: bsram_addr_seq (top)
// Address and cycle-control front end of a synchronous burst SRAM:
// captures addresses on strobes, sequences four-beat bursts in linear
// or interleaved order, reports the cycle type and a read data-valid flag.
// Assumes: synchronous active-low reset; BEAT_W low bits form the burst.
module bsram_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              chip_en,
    input  logic              adv_n,
    input  logic              wr_n,
    input  logic              order_sel,
    input  logic              oe_n,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        cycle_o,
    output logic              data_valid_o
);

    act_e              act;
    cyc_e              new_cyc;
    cyc_e              cyc_q;
    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] lo;

    bseq_strobe_dec u_dec (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_en       (chip_en),
        .adv_n         (adv_n),
        .wr_n          (wr_n),
        .cur_cyc       (cyc_q),
        .act           (act),
        .new_cyc       (new_cyc)
    );

    bseq_burst_state #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .new_cyc (new_cyc),
        .addr_i  (addr_i),
        .base_q  (base_q),
        .beat_q  (beat_q),
        .cyc_q   (cyc_q)
    );

    bseq_order_gen #(.BEAT_W(BEAT_W)) u_order (
        .first_lo  (base_q[BEAT_W-1:0]),
        .beat      (beat_q),
        .order_sel (order_sel),
        .lo        (lo)
    );

    // Drive the outputs from the burst state
    always_comb begin
        addr_o       = {base_q[ADDR_W-1:BEAT_W], lo};
        cycle_o      = cyc_q;
        data_valid_o = (cyc_q == CYC_READ) && !oe_n;
    end

endmodule

// File: rtl/bseq_checker.sv
// Module: bseq_checker
// Property checks on the sequencer ports, bound into the top module.
// Assumes: order_sel does not change in a cycle without a strobe.
module bseq_checker #(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              chip_en,
    input logic              adv_n,
    input logic              wr_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        cycle_o
);

    logic [BEAT_W-1:0] lo_inc;
    logic              no_strobe;

    assign lo_inc    = addr_o[BEAT_W-1:0] + BEAT_W'(1);
    assign no_strobe = proc_strobe_n && ctrl_strobe_n;

    AST_RESET_DESEL: assert property (@(posedge clk)
        !rst_n |=> (cycle_o == 2'b00 && addr_o == '0)); // R1

    AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && chip_en) |=>
        (cycle_o == 2'b01 && addr_o == $past(addr_i))); // R2

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && !ctrl_strobe_n && chip_en && !wr_n) |=>
        (cycle_o == 2'b10 && addr_o == $past(addr_i))); // R3

    AST_CTRL_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !chip_en) |=>
        (cycle_o == 2'b00 && $stable(addr_o))); // R4

    AST_BOTH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !ctrl_strobe_n && chip_en) |=>
        (cycle_o == 2'b01)); // R5

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !adv_n && cycle_o != 2'b00 && !order_sel) |=>
        (addr_o[BEAT_W-1:0] == $past(lo_inc))); // R6

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && adv_n) |=> $stable(addr_o)); // R8

    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        no_strobe |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R9

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && cycle_o == 2'b00) |=> $stable(addr_o)); // R12

endmodule

bind bsram_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr_i),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .chip_en       (chip_en),
    .adv_n         (adv_n),
    .wr_n          (wr_n),
    .order_sel     (order_sel),
    .addr_o        (addr_o),
    .cycle_o       (cycle_o)
);

// File: tb/bsram_addr_seq_bench.sv
// Directed bench for the burst address sequencer: one task per scenario.
module bsram_addr_seq_bench;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          chip_en = 1'b0;
    logic          adv_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          order_sel = 1'b0;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr_o;
    logic [1:0]    cycle_o;
    logic          data_valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bsram_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_bsram_addr_seq (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .chip_en(chip_en), .adv_n(adv_n), .wr_n(wr_n),
        .order_sel(order_sel), .oe_n(oe_n),
        .addr_o(addr_o), .cycle_o(cycle_o), .data_valid_o(data_valid_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, return at the next falling edge
    task automatic cyc(input logic p, input logic c, input logic ce,
                       input logic adv, input logic w, input logic [AW-1:0] a);
        proc_strobe_n = p; ctrl_strobe_n = c; chip_en = ce;
        adv_n = adv; wr_n = w; addr_i = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; oe_n = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 18'h3FFFF);
        chk("R1 cycle", 32'(cycle_o), 32'h0);
        chk("R1 addr", 32'(addr_o), 32'h0);
        chk("R1 valid", 32'(data_valid_o), 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_proc_read_linear();
        order_sel = 1'b0; oe_n = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h2A5C1);
        chk("R2 cycle", 32'(cycle_o), 32'h1);
        chk("R2 addr", 32'(addr_o), 32'h2A5C1);
        chk("R10 valid on", 32'(data_valid_o), 32'h1);
        oe_n = 1'b1; #1;
        chk("R10 valid off", 32'(data_valid_o), 32'h0);
        chk("R10 addr kept", 32'(addr_o), 32'h2A5C1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R6 beat1", 32'(addr_o), 32'h2A5C2);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0);
        chk("R8 wait", 32'(addr_o), 32'h2A5C2);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R6 beat2", 32'(addr_o), 32'h2A5C3);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R6 beat3", 32'(addr_o), 32'h2A5C0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R9 linear wrap", 32'(addr_o), 32'h2A5C1);
    endtask

    task automatic t_interleave();
        order_sel = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 18'h13579);
        chk("R7 first", 32'(addr_o), 32'h13579);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R7 beat1", 32'(addr_o), 32'h13578);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R7 beat2", 32'(addr_o), 32'h1357B);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R7 beat3", 32'(addr_o), 32'h1357A);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0);
        chk("R9 interleave wrap", 32'(addr_o), 32'h13579);
        order_sel = 1'b0;
    endtask

    task automatic t_ctrl();
        oe_n = 1'b0;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0ABC6);
        chk("R3 write cycle", 32'(cycle_o), 32'h2);
        chk("R3 write addr", 32'(addr_o), 32'h0ABC6);
        chk("R10 no valid on write", 32'(data_valid_o), 32'h0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 18'h11112);
        chk("R3 read cycle", 32'(cycle_o), 32'h1);
        chk("R3 read addr", 32'(addr_o), 32'h11112);
    endtask

    task automatic t_both();
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 18'h3C3C3);
        chk("R5 cycle", 32'(cycle_o), 32'h1);
        chk("R5 addr", 32'(addr_o), 32'h3C3C3);
    endtask

    task automatic t_proc_ignored();
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 18'h00007);
        chk("R11 cycle", 32'(cycle_o), 32'h1);
        chk("R11 addr", 32'(addr_o), 32'h3C3C3);
    endtask

    task automatic t_desel();
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 18'h15555);
        chk("R4 cycle", 32'(cycle_o), 32'h0);
        chk("R4 addr", 32'(addr_o), 32'h3C3C3);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
        chk("R12 addr", 32'(addr_o), 32'h3C3C3);
        chk("R12 cycle", 32'(cycle_o), 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_proc_read_linear();
        t_interleave();
        t_ctrl();
        t_both();
        t_proc_ignored();
        t_desel();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule